// File: doc/BRIEF.md
# USB Device Token Handshake Controller

This block sits behind the token decoder of a USB device port. It holds the device's control and status word and decides, for every decoded token, whether to answer and which handshake to give. A token that is not for this device, or that arrives while the device is disabled, gets no answer. A token that is for this device gets ACK or NAK. The choice depends on a sticky SETUP flag and on per-endpoint buffer-ready flags that software arms.

Each acknowledged transfer latches an interrupt bit for its endpoint and direction. A NAKed transfer latches one only when the interrupt-on-NAK enable for its class is set. There are four classes: control IN, control OUT, bulk/interrupt IN and bulk/interrupt OUT. Software reaches three words through a small register port: the control word (address 0), the buffer-ready flags (address 1, write one to set) and the interrupt flags (address 2, write one to clear).

Top module: `usb_token_hs`

## Requirements
- R1: After a synchronous reset, the control word reads 0x0800, the ready and interrupt words read 0, `hs_valid` is 0 and `irq` is 0.
- R2: The control word fields are as follows. Bits 6:0 hold the device address and bit 7 is the enable. Bit 9 keeps the clock on and bit 11 flags low-power support. Bits 15:12 are read/write. Bit 10 always reads 0. Bit 8 is the SETUP flag: writing 1 to it clears it and writing 0 leaves it unchanged.
- R3: A `bus_rst` pulse sets the address field to 0 on the next clock edge and leaves every other field unchanged.
- R4: The block answers a token only when all of the following hold: the enable is 1, the token address equals the stored address, the endpoint number is below NUM_EP, and the PID code is not 2'b00. PID codes are OUT=2'b01, IN=2'b10 and SETUP=2'b11. An unanswered token leaves `hs_valid`, the ready flags, the interrupt flags and the SETUP flag unchanged.
- R5: An answered SETUP token is always ACKed. It sets the SETUP flag and clears both endpoint 0 ready flags.
- R6: While the SETUP flag is set, every answered IN or OUT token is NAKed and no ready flag changes.
- R7: While the SETUP flag is clear, an answered IN or OUT token is ACKed exactly when its ready flag is set, and the ACK clears that flag. The ready word holds OUT flags at bit ep and IN flags at bit NUM_EP+ep, and writing 1 to a bit sets it.
- R8: `hs_valid` and `hs_ack` appear one clock after the token strobe and last exactly one cycle.
- R9: An ACKed transfer sets interrupt bit ep (OUT or SETUP) or NUM_EP+ep (IN). The bit appears on `irq` and in the interrupt word in the same cycle as `hs_valid`, and it stays set until software writes 1 to it.
- R10: A NAKed transfer sets its interrupt bit only if the enable for its class is 1. The enables are: bit 12 for bulk/interrupt OUT, bit 13 for bulk/interrupt IN, bit 14 for control OUT and bit 15 for control IN. `tok_ctrl`=1 marks a control transfer.
- R11: When a state-setting event and a software write land on the same edge, the event wins in each of these cases: a new SETUP acknowledge beats a clear of the SETUP flag, a new interrupt beats its clear, and a ready-set write beats the clear caused by an ACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rst | input | 1 | Bus reset pulse |
| tok_valid | input | 1 | Token strobe |
| tok_pid | input | 2 | Token PID code |
| tok_addr | input | 7 | Token function address |
| tok_ep | input | 4 | Token endpoint number |
| tok_ctrl | input | 1 | 1 = control endpoint, 0 = bulk/interrupt |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| hs_valid | output | 1 | Handshake is issued this cycle |
| hs_ack | output | 1 | 1 = ACK, 0 = NAK (valid with hs_valid) |
| irq | output | 2*NUM_EP | Per-endpoint interrupt lines, OUT low half, IN high half |

## Verification
The handshake, the interrupt bit, the ready-flag clear and the SETUP flag all update on the first rising edge after the strobe is presented. The bench drives each token at a falling edge and samples all four at the next falling edge. It then checks at the following falling edge that `hs_valid` has dropped. Register writes take effect on the edge that samples them, and reads are combinational, so each read is taken one falling edge after the write. A sweep covers every endpoint, direction, type, ready state and NAK-enable combination, with the expected ACK and interrupt computed from R7 and R10.

// File: rtl/usb_tok_pkg.sv
// Shared types for the token handshake controller.
// Assumes register words are 16 bits and endpoint numbers are 4 bits.
package usb_tok_pkg;
    localparam int REG_W = 16;
    localparam int EPN_W = 4;

    localparam logic [1:0] PID_NONE  = 2'b00;
    localparam logic [1:0] PID_OUT   = 2'b01;
    localparam logic [1:0] PID_IN    = 2'b10;
    localparam logic [1:0] PID_SETUP = 2'b11;

    localparam logic [1:0] RA_CMD = 2'd0;
    localparam logic [1:0] RA_RDY = 2'd1;
    localparam logic [1:0] RA_IRQ = 2'd2;

    // nak_en: [0] bulk OUT, [1] bulk IN, [2] control OUT, [3] control IN
    typedef struct packed {
        logic [3:0] nak_en;
        logic       lpm;
        logic       clk_keep;
        logic       setup;
        logic       en;
        logic [6:0] addr;
    } cmd_t;
endpackage

// File: rtl/hs_cmd_reg.sv
// Control/status word storage.
// Assumes: wr_en already decoded for the control word address; bus_rst
// overrides a same-cycle address write; a SETUP acknowledge overrides a
// same-cycle write-one-to-clear of the SETUP flag.
module hs_cmd_reg
    import usb_tok_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             setup_ack,
    output cmd_t             cmd
);
    logic unused_rsvd;
    assign unused_rsvd = wdata[10];

    // Update the fields from writes, bus reset and SETUP acknowledges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd     <= '0;
            cmd.lpm <= 1'b1;
        end else begin
            if (bus_rst)
                cmd.addr <= '0;
            else if (wr_en)
                cmd.addr <= wdata[6:0];
            if (wr_en) begin
                cmd.en       <= wdata[7];
                cmd.clk_keep <= wdata[9];
                cmd.lpm      <= wdata[11];
                cmd.nak_en   <= wdata[15:12];
            end
            if (setup_ack)
                cmd.setup <= 1'b1;
            else if (wr_en && wdata[8])
                cmd.setup <= 1'b0;
        end
    end

    // R5, R11
    setup_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        setup_ack |=> cmd.setup);
    // R3
    bus_rst_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> (cmd.addr == 7'd0));
endmodule

// File: rtl/hs_decide.sv
// Token decision logic. It forms the respond/ACK decision for the strobed
// token, registers the handshake, and emits same-cycle event vectors that
// update the ready and interrupt state.
// Assumes tok_* are only meaningful while tok_valid is high.
module hs_decide
    import usb_tok_pkg::*;
#(
    parameter int NUM_EP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tok_valid,
    input  logic [1:0]        tok_pid,
    input  logic [6:0]        tok_addr,
    input  logic [EPN_W-1:0]  tok_ep,
    input  logic              tok_ctrl,
    input  logic              dev_en,
    input  logic [6:0]        dev_addr,
    input  logic              setup_flag,
    input  logic [3:0]        nak_en,
    input  logic [NUM_EP-1:0] rdy_out,
    input  logic [NUM_EP-1:0] rdy_in,
    output logic              hs_valid,
    output logic              hs_ack,
    output logic              setup_ack,
    output logic [NUM_EP-1:0] out_clr,
    output logic [NUM_EP-1:0] in_clr,
    output logic [NUM_EP-1:0] irq_out_set,
    output logic [NUM_EP-1:0] irq_in_set
);
    logic [NUM_EP-1:0] sel;
    logic respond, is_in, is_out, is_setup, rdy_hit, ack, nak_ok, raise;

    for (genvar i = 0; i < NUM_EP; i++) begin : g_sel
        assign sel[i] = (tok_ep == EPN_W'(i));
    end

    // Decide whether to answer and with which handshake.
    always_comb begin
        is_in    = (tok_pid == PID_IN);
        is_out   = (tok_pid == PID_OUT);
        is_setup = (tok_pid == PID_SETUP);
        respond  = tok_valid && dev_en && (tok_addr == dev_addr)
                   && ({1'b0, tok_ep} < (EPN_W+1)'(NUM_EP))
                   && (tok_pid != PID_NONE);
        rdy_hit  = |(sel & (is_in ? rdy_in : rdy_out));
        ack      = is_setup || (!setup_flag && rdy_hit);
        nak_ok   = nak_en[{tok_ctrl, is_in}];
        raise    = respond && (ack || nak_ok);
    end

    // Event vectors for the endpoint state.
    always_comb begin
        setup_ack   = respond && is_setup;
        in_clr      = (respond && is_in  && ack) ? sel : '0;
        out_clr     = (respond && is_out && ack) ? sel : '0;
        irq_in_set  = (raise && is_in)  ? sel : '0;
        irq_out_set = (raise && !is_in) ? sel : '0;
    end

    // Register the handshake one clock after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_valid <= 1'b0;
            hs_ack   <= 1'b0;
        end else begin
            hs_valid <= respond;
            hs_ack   <= respond && ack;
        end
    end

    // R8
    no_strobe_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tok_valid |=> !hs_valid);
    // R6
    setup_forces_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && setup_flag && (tok_pid == PID_IN || tok_pid == PID_OUT))
        |=> !hs_ack);
    // R5
    setup_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        setup_ack |=> (hs_valid && hs_ack));
    // R4
    ack_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hs_ack |-> hs_valid);
endmodule

// File: rtl/hs_ep_state.sv
// Per-endpoint buffer-ready flags (write one to set) and sticky interrupt
// flags (write one to clear), one instance per endpoint via generate.
// Assumes wdata bit ep is OUT and bit NUM_EP+ep is IN for both words.
module hs_ep_state #(
    parameter int NUM_EP = 4,
    localparam int W     = 2 * NUM_EP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rdy_wr,
    input  logic              irq_wr,
    input  logic [W-1:0]      wdata,
    input  logic              setup_ack,
    input  logic [NUM_EP-1:0] out_clr,
    input  logic [NUM_EP-1:0] in_clr,
    input  logic [NUM_EP-1:0] irq_out_set,
    input  logic [NUM_EP-1:0] irq_in_set,
    output logic [NUM_EP-1:0] rdy_out,
    output logic [NUM_EP-1:0] rdy_in,
    output logic [NUM_EP-1:0] irq_out,
    output logic [NUM_EP-1:0] irq_in
);
    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        localparam bit IS_EP0 = (i == 0);
        logic ro_q, ri_q, io_q, ii_q, ep0_wipe;
        assign ep0_wipe = IS_EP0 && setup_ack;

        // Ready flags: software set wins over hardware clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ro_q <= 1'b0;
                ri_q <= 1'b0;
            end else begin
                ro_q <= (ro_q && !out_clr[i] && !ep0_wipe) || (rdy_wr && wdata[i]);
                ri_q <= (ri_q && !in_clr[i]  && !ep0_wipe) || (rdy_wr && wdata[NUM_EP+i]);
            end
        end

        // Interrupt flags: new event wins over software clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                io_q <= 1'b0;
                ii_q <= 1'b0;
            end else begin
                io_q <= (io_q && !(irq_wr && wdata[i]))        || irq_out_set[i];
                ii_q <= (ii_q && !(irq_wr && wdata[NUM_EP+i])) || irq_in_set[i];
            end
        end

        assign rdy_out[i] = ro_q;
        assign rdy_in[i]  = ri_q;
        assign irq_out[i] = io_q;
        assign irq_in[i]  = ii_q;

        // R9
        irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ii_q && !(irq_wr && wdata[NUM_EP+i])) |=> ii_q);
        // R7
        rdy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ro_q && !out_clr[i] && !ep0_wipe) |=> ro_q);
    end
endmodule

// File: rtl/usb_token_hs.sv
// Top level of the token handshake controller: register port decode,
// control word, token decision and endpoint state.
// Assumes 2*NUM_EP <= 16 so both endpoint words fit one register.
module usb_token_hs
    import usb_tok_pkg::*;
#(
    parameter int NUM_EP = 4,
    localparam int W     = 2 * NUM_EP
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_rst,
    input  logic             tok_valid,
    input  logic [1:0]       tok_pid,
    input  logic [6:0]       tok_addr,
    input  logic [EPN_W-1:0] tok_ep,
    input  logic             tok_ctrl,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             hs_valid,
    output logic             hs_ack,
    output logic [W-1:0]     irq
);
    cmd_t cmd;
    logic setup_ack;
    logic [NUM_EP-1:0] out_clr, in_clr, irq_out_set, irq_in_set;
    logic [NUM_EP-1:0] rdy_out, rdy_in, irq_out, irq_in;
    logic cmd_wr, rdy_wr, irq_wr;

    assign cmd_wr = reg_we && (reg_addr == RA_CMD);
    assign rdy_wr = reg_we && (reg_addr == RA_RDY);
    assign irq_wr = reg_we && (reg_addr == RA_IRQ);

    hs_cmd_reg u_cmd (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .wr_en(cmd_wr),
        .wdata(reg_wdata), .setup_ack(setup_ack), .cmd(cmd)
    );

    hs_decide #(.NUM_EP(NUM_EP)) u_dec (
        .clk(clk), .rst_n(rst_n), .tok_valid(tok_valid), .tok_pid(tok_pid),
        .tok_addr(tok_addr), .tok_ep(tok_ep), .tok_ctrl(tok_ctrl),
        .dev_en(cmd.en), .dev_addr(cmd.addr), .setup_flag(cmd.setup),
        .nak_en(cmd.nak_en), .rdy_out(rdy_out), .rdy_in(rdy_in),
        .hs_valid(hs_valid), .hs_ack(hs_ack), .setup_ack(setup_ack),
        .out_clr(out_clr), .in_clr(in_clr),
        .irq_out_set(irq_out_set), .irq_in_set(irq_in_set)
    );

    hs_ep_state #(.NUM_EP(NUM_EP)) u_ep (
        .clk(clk), .rst_n(rst_n), .rdy_wr(rdy_wr), .irq_wr(irq_wr),
        .wdata(reg_wdata[W-1:0]), .setup_ack(setup_ack),
        .out_clr(out_clr), .in_clr(in_clr),
        .irq_out_set(irq_out_set), .irq_in_set(irq_in_set),
        .rdy_out(rdy_out), .rdy_in(rdy_in), .irq_out(irq_out), .irq_in(irq_in)
    );

    assign irq = {irq_in, irq_out};

    // Combinational read mux; bit 10 of the control word is tied low.
    always_comb begin
        case (reg_addr)
            RA_CMD:  reg_rdata = {cmd.nak_en, cmd.lpm, 1'b0, cmd.clk_keep,
                                  cmd.setup, cmd.en, cmd.addr};
            RA_RDY:  reg_rdata = REG_W'({rdy_in, rdy_out});
            RA_IRQ:  reg_rdata = REG_W'({irq_in, irq_out});
            default: reg_rdata = '0;
        endcase
    end

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == RA_CMD) |-> (reg_rdata[10] == 1'b0));
    // R9
    irq_follows_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_valid && hs_ack) |-> (irq != '0));
endmodule

// File: tb/tb_usb_token_hs.sv
module tb_usb_token_hs;
    localparam int NUM_EP = 4;
    localparam logic [6:0] DA = 7'h2A;

    logic clk = 1'b0;
    logic rst_n = 1'b0, bus_rst = 1'b0, tok_valid = 1'b0, tok_ctrl = 1'b0, reg_we = 1'b0;
    logic [1:0] tok_pid = 2'b00, reg_addr = 2'b00;
    logic [6:0] tok_addr = 7'h0;
    logic [3:0] tok_ep = 4'h0;
    logic [15:0] reg_wdata = 16'h0, reg_rdata;
    logic hs_valid, hs_ack;
    logic [2*NUM_EP-1:0] irq;
    int n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    usb_token_hs #(.NUM_EP(NUM_EP)) dut (
        .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .tok_valid(tok_valid),
        .tok_pid(tok_pid), .tok_addr(tok_addr), .tok_ep(tok_ep), .tok_ctrl(tok_ctrl),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .hs_valid(hs_valid), .hs_ack(hs_ack), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [1:0] a, input logic [15:0] exp);
        reg_addr = a; #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic tok(input logic [1:0] pid, input logic [6:0] ad, input logic [3:0] ep,
                       input logic ct, output logic v, output logic k);
        @(negedge clk);
        tok_valid = 1'b1; tok_pid = pid; tok_addr = ad; tok_ep = ep; tok_ctrl = ct;
        @(negedge clk);
        v = hs_valid; k = hs_ack;
        tok_valid = 1'b0; tok_pid = 2'b00;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic v, k;
        do_reset();
        // R1 reset state
        rd_chk("R1 cmd", 2'd0, 16'h0800);
        rd_chk("R1 rdy", 2'd1, 16'h0000);
        rd_chk("R1 irqw", 2'd2, 16'h0000);
        chk("R1 hs_valid", hs_valid, 0);
        chk("R1 irq", irq, 0);

        // R2 field access
        wr(2'd0, 16'hFFFF);
        rd_chk("R2 all ones", 2'd0, 16'hFAFF);
        wr(2'd0, 16'h0000);
        rd_chk("R2 all zeros", 2'd0, 16'h0000);

        // R4 ignored tokens
        do_reset();
        wr(2'd0, 16'hF000 | 16'h0080 | 16'(DA));
        wr(2'd1, 16'h00FF);
        tok(2'b10, DA + 7'd1, 4'd1, 1'b0, v, k); chk("R4 wrong addr", v, 0);
        tok(2'b10, DA, 4'd5, 1'b0, v, k);        chk("R4 ep out of range", v, 0);
        tok(2'b00, DA, 4'd1, 1'b0, v, k);        chk("R4 null pid", v, 0);
        wr(2'd0, 16'hF000 | 16'(DA));
        tok(2'b10, DA, 4'd1, 1'b0, v, k);        chk("R4 disabled", v, 0);
        rd_chk("R4 rdy untouched", 2'd1, 16'h00FF);
        rd_chk("R4 irq untouched", 2'd2, 16'h0000);
        rd_chk("R4 setup untouched", 2'd0, 16'hF000 | 16'(DA));

        // R5 / R6 SETUP handling
        do_reset();
        wr(2'd0, 16'h0080 | 16'(DA));
        wr(2'd1, 16'h00FF);
        tok(2'b11, DA, 4'd0, 1'b1, v, k);
        chk("R5 setup valid", v, 1); chk("R5 setup ack", k, 1);
        rd_chk("R5 flag set", 2'd0, 16'h0180 | 16'(DA));
        rd_chk("R5 ep0 ready wiped", 2'd1, 16'h00EE);
        tok(2'b10, DA, 4'd1, 1'b0, v, k);
        chk("R6 in valid", v, 1); chk("R6 in nak", k, 0);
        tok(2'b01, DA, 4'd2, 1'b0, v, k);
        chk("R6 out nak", k, 0);
        rd_chk("R6 ready kept", 2'd1, 16'h00EE);
        wr(2'd0, 16'h0080 | 16'(DA));
        rd_chk("R2 write zero keeps setup", 2'd0, 16'h0180 | 16'(DA));
        wr(2'd0, 16'h0180 | 16'(DA));
        rd_chk("R2 write one clears setup", 2'd0, 16'h0080 | 16'(DA));
        tok(2'b10, DA, 4'd1, 1'b0, v, k);
        chk("R7 in ack after clear", k, 1);
        rd_chk("R7 ready consumed", 2'd1, 16'h00CE);
        // R9 sticky interrupts and clear
        repeat (5) @(negedge clk);
        rd_chk("R9 irq sticky", 2'd2, 16'h0021);
        wr(2'd2, 16'h0001);
        chk("R9 irq port after clear", irq, 8'h20);

        // R8 timing
        do_reset();
        wr(2'd0, 16'h0080 | 16'(DA));
        @(negedge clk);
        tok_valid = 1'b1; tok_pid = 2'b01; tok_addr = DA; tok_ep = 4'd3; tok_ctrl = 1'b0;
        chk("R8 not before edge", hs_valid, 0);
        @(negedge clk);
        chk("R8 one clock after", hs_valid, 1);
        tok_valid = 1'b0;
        @(negedge clk);
        chk("R8 single pulse", hs_valid, 0);

        // R3 bus reset
        do_reset();
        wr(2'd0, 16'hF280 | 16'(DA));
        @(negedge clk); bus_rst = 1'b1;
        @(negedge clk); bus_rst = 1'b0;
        rd_chk("R3 addr zeroed", 2'd0, 16'hF280);
        tok(2'b01, 7'd0, 4'd0, 1'b1, v, k);
        chk("R3 answers addr 0", v, 1);

        // R11 same-edge priorities
        do_reset();
        wr(2'd0, 16'h0080 | 16'(DA));
        @(negedge clk);
        tok_valid = 1'b1; tok_pid = 2'b11; tok_addr = DA; tok_ep = 4'd0; tok_ctrl = 1'b1;
        reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0180 | 16'(DA);
        @(negedge clk); tok_valid = 1'b0; reg_we = 1'b0;
        rd_chk("R11 setup beats clear", 2'd0, 16'h0180 | 16'(DA));
        wr(2'd0, 16'h0180 | 16'(DA));
        wr(2'd1, 16'h0004);
        @(negedge clk);
        tok_valid = 1'b1; tok_pid = 2'b01; tok_ep = 4'd2; tok_ctrl = 1'b0;
        reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 16'h0004;
        @(negedge clk); tok_valid = 1'b0; reg_we = 1'b0;
        rd_chk("R11 irq beats clear", 2'd2, 16'h0005);
        rd_chk("R11 ready consumed", 2'd1, 16'h0000);
        wr(2'd1, 16'h0004);
        @(negedge clk);
        tok_valid = 1'b1; tok_pid = 2'b01; tok_ep = 4'd2;
        reg_we = 1'b1; reg_addr = 2'd1; reg_wdata = 16'h0004;
        @(negedge clk); tok_valid = 1'b0; reg_we = 1'b0;
        rd_chk("R11 set beats consume", 2'd1, 16'h0004);

        // R7 / R10 sweep
        for (int dir = 0; dir < 2; dir++)
            for (int ct = 0; ct < 2; ct++)
                for (int rdy = 0; rdy < 2; rdy++)
                    for (int en = 0; en < 16; en++)
                        for (int ep = 0; ep < NUM_EP; ep++) begin
                            int bitn;
                            int cls;
                            logic exp_irq;
                            bitn = dir ? NUM_EP + ep : ep;
                            cls = ct * 2 + dir;
                            exp_irq = (rdy != 0) || en[cls];
                            do_reset();
                            wr(2'd0, 16'(en << 12) | 16'h0080 | 16'(DA));
                            if (rdy != 0) wr(2'd1, 16'(1 << bitn));
                            tok(dir ? 2'b10 : 2'b01, DA, 4'(ep), ct[0], v, k);
                            chk("R7 sweep valid", v, 1);
                            chk("R7 sweep ack", k, 32'(rdy));
                            chk("R10 sweep irq", irq, exp_irq ? 32'(1 << bitn) : 0);
                            rd_chk("R7 sweep ready", 2'd1, 16'h0000);
                        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule